// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Interrupt

This block is an 8-bit down-counting watchdog. A prescaler divides the system clock into a slow tick. While the watchdog runs, the counter steps down by one on every tick. Software restarts it with a control write before it runs out. One tick before expiry the block raises a single-cycle non-maskable interrupt request. Handler code can use that window to record state before the chip is reset. When the count reaches zero, a chip-reset request is driven for a fixed number of system clocks.

A control write carries three things: a start or stop command, a reload value and a 7-bit key. A command takes effect only if its key is the bitwise complement of the key of the last accepted command. A runaway program therefore cannot keep the watchdog alive, or stop it, by writing the same word over and over. Writes with a wrong key leave the block untouched. Status outputs show the run flag, the live count and the last accepted key.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, the count and stored key read 0, and `nmi_o` and `chip_rst_o` are low. Until the first command is accepted, a stop write (`wr_cmd`=0) is ignored and a start write (`wr_cmd`=1) is accepted with any key.
- R2: Once a key is stored, a write is accepted only if `wr_key` equals the stored key XOR 7'h7F. A rejected write leaves the count, the run flag and the stored key unchanged. An accepted write stores its key.
- R3: An accepted start loads `wr_count` and sets the run flag, whether or not the watchdog was already running. It also restarts the prescaler, so the first decrement lands exactly TICK_DIV clocks after the write edge.
- R4: While running, the count decreases by one every TICK_DIV system clocks (default 131072). While stopped, the count holds.
- R5: An accepted stop (`wr_cmd`=0) clears the run flag and keeps the current count.
- R6: `nmi_o` is high for exactly one clock, starting at the edge where a tick moves the count from 2 to 1.
- R7: A tick that finds the count at 1 or 0 while running sets the count to 0 and clears the run flag. From that edge, `chip_rst_o` is high for exactly RST_CYCLES clocks (default 4).
- R8: When an accepted command and a tick fall in the same cycle, the command takes effect and the tick is discarded. No decrement, NMI or reset comes from that tick.
- R9: `st_running`, `st_count` and `st_key` show the run flag, the current count and the last accepted key, one clock after the edge that changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe, one cycle |
| wr_cmd | input | 1 | 1 = start/restart, 0 = stop |
| wr_key | input | KEY_W | Key carried by the write |
| wr_count | input | CNT_W | Reload value for a start |
| nmi_o | output | 1 | Early-warning non-maskable interrupt request |
| chip_rst_o | output | 1 | Chip-reset request |
| st_running | output | 1 | Run flag |
| st_count | output | CNT_W | Current count |
| st_key | output | KEY_W | Last accepted key |

## Verification
Two kinds of event can land in the same clock: an accepted command and a prescaler tick that would decrement the count, raise the NMI or expire the watchdog. The bench waits exactly TICK_DIV-1 clocks after a restart, so the next write strobe coincides with the tick edge. It does this once with a restart that would otherwise have caused an NMI, and once with a stop that would otherwise have caused a reset. It then checks the count, run flag, NMI and reset outputs against the rule that the command wins and the tick is lost.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic {
        CMD_STOP  = 1'b0,
        CMD_START = 1'b1
    } wdog_cmd_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int unsigned TICK_DIV = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.phase == LAST);
        if (restart_i)
            st_d.phase = '0;
        else if (at_end)
            st_d.phase = '0;
        else
            st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = at_end;

    // R4: ticks are spaced apart, never two in a row
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_key_gate.sv
module wdog_key_gate
    import wdog_pkg::*;
#(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept_o,
    output logic [KEY_W-1:0] key_o
);
    typedef struct packed {
        logic             armed;
        logic [KEY_W-1:0] key;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     match;

    always_comb begin
        st_d = st_q;
        if (st_q.armed)
            match = (wr_key == (st_q.key ^ {KEY_W{1'b1}}));
        else
            match = (wdog_cmd_e'(wr_cmd) == CMD_START);
        accept_o = wr_en && match;
        if (accept_o) begin
            st_d.armed = 1'b1;
            st_d.key   = wr_key;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_o = st_q.key;

    // R2: a rejected write never disturbs the stored key
    a_r2_reject_keeps_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept_o) |=> ($stable(key_o) && $stable(st_q.armed)));
    // R1: once a key is stored the gate stays armed
    a_r1_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> st_q.armed);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int CNT_W      = 8,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cmd_valid_i,
    input  logic             cmd_start_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o,
    output logic             nmi_o,
    output logic             chip_rst_o
);
    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] count;
        logic             nmi;
        logic [RW-1:0]    rst_left;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.nmi = 1'b0;
        if (st_q.rst_left != '0)
            st_d.rst_left = st_q.rst_left - 1'b1;
        if (cmd_valid_i) begin
            if (cmd_start_i) begin
                st_d.run   = 1'b1;
                st_d.count = load_i;
            end else begin
                st_d.run = 1'b0;
            end
        end else if (tick_i && st_q.run) begin
            if (st_q.count <= ONE) begin
                st_d.count    = '0;
                st_d.run      = 1'b0;
                st_d.rst_left = RW'(RST_CYCLES);
            end else begin
                st_d.count = st_q.count - 1'b1;
                st_d.nmi   = (st_q.count == TWO);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running_o  = st_q.run;
    assign count_o    = st_q.count;
    assign nmi_o      = st_q.nmi;
    assign chip_rst_o = (st_q.rst_left != '0);

    // R6: the warning lasts a single clock
    a_r6_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);
    // R6: the warning coincides with a count of 1
    a_r6_nmi_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (count_o == ONE && running_o));
    // R7: reset request starts with the watchdog expired
    a_r7_reset_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_o) |-> (count_o == '0 && !running_o));
    // R4: a stopped watchdog keeps its count without a command
    a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !cmd_valid_i) |=> $stable(count_o));
    // R8: a command in a tick cycle suppresses the warning
    a_r8_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> !nmi_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdog_pkg::*;
#(
    parameter int          CNT_W      = 8,
    parameter int          KEY_W      = 7,
    parameter int unsigned TICK_DIV   = 131072,
    parameter int          RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [CNT_W-1:0] wr_count,
    output logic             nmi_o,
    output logic             chip_rst_o,
    output logic             st_running,
    output logic [CNT_W-1:0] st_count,
    output logic [KEY_W-1:0] st_key
);
    logic accept;
    logic is_start;
    logic tick;

    assign is_start = (wdog_cmd_e'(wr_cmd) == CMD_START);

    wdog_key_gate #(.KEY_W(KEY_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cmd   (wr_cmd),
        .wr_key   (wr_key),
        .accept_o (accept),
        .key_o    (st_key)
    );

    wdog_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept && is_start),
        .tick_o    (tick)
    );

    wdog_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cmd_valid_i (accept),
        .cmd_start_i (is_start),
        .load_i      (wr_count),
        .running_o   (st_running),
        .count_o     (st_count),
        .nmi_o       (nmi_o),
        .chip_rst_o  (chip_rst_o)
    );

    // R3: an accepted start is visible as running with the loaded value
    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_start) |=> (st_running && st_count == $past(wr_count)));
    // R5: an accepted stop halts the watchdog
    a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_start) |=> !st_running);
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
    localparam int DIV = 8;
    localparam int NV  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [6:0] wr_key = '0;
    logic [7:0] wr_count = '0;
    logic       nmi_o, chip_rst_o, st_running;
    logic [7:0] st_count;
    logic [6:0] st_key;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    keyed_watchdog #(.TICK_DIV(DIV), .RST_CYCLES(4)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_key(wr_key), .wr_count(wr_count), .nmi_o(nmi_o),
        .chip_rst_o(chip_rst_o), .st_running(st_running),
        .st_count(st_count), .st_key(st_key)
    );

    // {cmd, key, count, wait, exp_run, exp_count, exp_key}
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 7'h2A, 8'd10,  8'd0,  1'b1, 8'd10,  7'h2A},
        {1'b1, 7'h55, 8'd20,  8'd16, 1'b1, 8'd18,  7'h55},
        {1'b1, 7'h55, 8'd5,   8'd8,  1'b1, 8'd17,  7'h55},
        {1'b0, 7'h2A, 8'd0,   8'd8,  1'b0, 8'd17,  7'h2A},
        {1'b0, 7'h55, 8'd0,   8'd0,  1'b0, 8'd17,  7'h55},
        {1'b1, 7'h2A, 8'd3,   8'd4,  1'b1, 8'd3,   7'h2A},
        {1'b1, 7'h2A, 8'd99,  8'd3,  1'b1, 8'd2,   7'h2A},
        {1'b1, 7'h55, 8'd200, 8'd0,  1'b1, 8'd200, 7'h55}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic c, input logic [6:0] k, input logic [7:0] v);
        wr_en = 1'b1; wr_cmd = c; wr_key = k; wr_count = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int highs;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 run", st_running, 0);
        chk("R1 count", st_count, 0);
        chk("R1 key", st_key, 0);
        chk("R1 nmi", nmi_o, 0);
        chk("R1 chip_rst", chip_rst_o, 0);
        wr(1'b0, 7'h11, 8'd0);
        chk("R1 early stop ignored key", st_key, 0);
        chk("R1 early stop ignored run", st_running, 0);

        // Vector table: R2 R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][39], VEC[i][38:32], VEC[i][31:24]);
            step(int'(VEC[i][23:16]));
            chk("R9 run", st_running, int'(VEC[i][15]));
            chk("R4 count", st_count, int'(VEC[i][14:7]));
            chk("R2 key", st_key, int'(VEC[i][6:0]));
        end

        // R6 / R7 expiry sequence (last key 55)
        wr(1'b1, 7'h2A, 8'd3);
        step(DIV);
        chk("R4 count after tick", st_count, 2);
        step(DIV - 1);
        chk("R6 nmi before tick", nmi_o, 0);
        step(1);
        chk("R6 count 1", st_count, 1);
        chk("R6 nmi pulse", nmi_o, 1);
        step(1);
        chk("R6 nmi one cycle", nmi_o, 0);
        step(DIV - 2);
        chk("R7 no reset yet", chip_rst_o, 0);
        step(1);
        chk("R7 reset rises", chip_rst_o, 1);
        chk("R7 count 0", st_count, 0);
        chk("R7 stopped", st_running, 0);
        highs = 1;
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (chip_rst_o) highs++;
        end
        chk("R7 reset width", highs, 4);

        // R8: restart lands on the tick that would raise NMI (key now 2A)
        wr(1'b1, 7'h55, 8'd2);
        step(DIV - 1);
        wr(1'b1, 7'h2A, 8'd2);
        chk("R8 restart wins count", st_count, 2);
        chk("R8 restart wins nmi", nmi_o, 0);
        step(DIV);
        chk("R3 first tick after restart", st_count, 1);
        chk("R6 nmi after restart", nmi_o, 1);
        // R8: stop lands on the tick that would expire
        step(DIV - 1);
        wr(1'b0, 7'h55, 8'd0);
        chk("R8 stop wins run", st_running, 0);
        chk("R8 stop wins count", st_count, 1);
        highs = 0;
        for (int i = 0; i < 2 * DIV; i++) begin
            step(1);
            if (chip_rst_o) highs++;
        end
        chk("R8 no reset after stop", highs, 0);
        chk("R5 count held", st_count, 1);

        // R7: start with 0 expires on first tick
        wr(1'b1, 7'h2A, 8'd0);
        step(DIV);
        chk("R7 zero start reset", chip_rst_o, 1);
        chk("R7 zero start stopped", st_running, 0);
        step(6);
        chk("R7 reset released", chip_rst_o, 0);

        finish_run();
    end
endmodule